// File: doc/BRIEF.md
# Write Protection and Status Unit

This unit keeps the protection and status state of a 512-byte serial nonvolatile memory. A serial front end decodes each transaction and hands the unit one command event per clock: set or clear the write-enable latch, a status write with its data byte, an array write with its start address and byte count, an array read, or a status read. The unit also watches an active-low hardware write-protect pin. It decides whether each event is accepted or refused, and it times the self-timed internal write cycle that follows an accepted array or status write.

The assembled status byte is driven as a port, so the front end can shift it out at any time, including while a cycle runs. Two block-protect bits pick which quarters of the address space refuse array writes. The cycle length is a parameter counted in system clocks. One clock after each command the unit answers with a one-clock accept or refuse pulse.

Top module: `nvm_guard_status`

## Requirements
- R1: The status byte has the in-progress flag in bit 0, the write-enable latch in bit 1, protect bit 0 in bit 2 and protect bit 1 in bit 3, and bits 7 to 4 read as zero. After reset the whole byte is zero.
- R2: An array write is refused when its start address lies in the protected range. Protect code 00 protects nothing, 01 protects 0x180-0x1FF, 10 protects 0x100-0x1FF, and 11 protects 0x000-0x1FF.
- R3: When the pin is high, a set-latch command sets the write-enable latch and a clear-latch command clears it. Both work whatever the protect code.
- R4: While the pin is low and no cycle runs, the latch is cleared by the next clock, and a set-latch command leaves it at zero.
- R5: An array write or status write is refused when the latch is zero or the pin is low. A refused array write leaves the latch unchanged.
- R6: An accepted array write or status write sets the in-progress flag for exactly CYCLE_CLKS clocks, starting the clock after the command. The latch clears when the cycle ends.
- R7: Taking the pin low during a cycle does not shorten the cycle and does not clear the latch early.
- R8: While a cycle runs, a status read is accepted. Every other command, including an array read, is refused and changes no state.
- R9: The protect bits change only through an accepted status write, which loads data bits 3:2 into them. Set-latch, clear-latch and the pin leave them unchanged.
- R10: An array write that carries a byte count of zero is refused.
- R11: Command codes are 1 set-latch, 2 clear-latch, 3 status write, 4 array write, 5 array read and 6 status read. Every valid command gets exactly one accept or refuse pulse, one clock after it; other codes are refused. Without a command neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | A command event is present this clock |
| cmd_op | input | 3 | Command code (R11) |
| cmd_data | input | 8 | Data byte of a status write |
| cmd_addr | input | ADDR_W | Start address of an array write |
| cmd_count | input | PAGE_W+1 | Byte count of an array write |
| wp_n | input | 1 | Hardware write-protect pin, low protects |
| status | output | 8 | Assembled status byte |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Internal write cycle in progress |
| bp | output | 2 | Block-protect code |
| cmd_acc | output | 1 | Command accepted pulse |
| cmd_rej | output | 1 | Command refused pulse |

## Verification
Array writes are aimed just below and at the start of each protected range under all four protect codes. This shows whether the decode splits the address space at the right quarter and whether a status write can still change the code when everything is protected. Writes are also sent with the latch at zero, with the pin low, and with a zero byte count, so each of the three refusal causes is seen on its own. During cycles the bench sends reads, status reads and latch commands and pulses the pin low, which tells an ignored command apart from one that quietly changes state or ends the cycle early. Every clock of each cycle is compared, so an off-by-one in the cycle length is caught.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

   typedef enum logic [2:0] {
      GOP_NONE  = 3'd0,
      GOP_SETWE = 3'd1,
      GOP_CLRWE = 3'd2,
      GOP_STWR  = 3'd3,
      GOP_ARWR  = 3'd4,
      GOP_ARRD  = 3'd5,
      GOP_STRD  = 3'd6
   } guard_op_e;

   // status byte bit positions; the status-write data uses the same layout
   localparam int ST_BUSY_BIT = 0;
   localparam int ST_WEL_BIT  = 1;
   localparam int ST_BP_LSB   = 2;
   localparam int ST_BP_W     = 2;
   localparam int ST_W        = 8;

endpackage

// File: rtl/nvm_guard_region.sv
module nvm_guard_region #(
   parameter int ADDR_W = 9
) (
   input  logic [1:0]        bp_code,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int NCODE = 4;

   logic [1:0]       quarter;
   logic [NCODE-1:0] code_hit;

   if (ADDR_W < 3) begin : g_bad_addr_w
      initial $fatal(1, "nvm_guard_region: ADDR_W must be at least 3");
   end

   assign quarter = addr[ADDR_W-1 -: 2];

   // code c (c>0) protects the top 2**(c-1) quarters
   for (genvar c = 0; c < NCODE; c++) begin : g_code
      if (c == 0) begin : g_none
         assign code_hit[c] = 1'b0;
      end else begin : g_quarters
         localparam int LOW_Q = NCODE - (1 << (c - 1));
         assign code_hit[c] = (quarter >= 2'(LOW_Q));
      end
   end

   assign hit = code_hit[bp_code];

endmodule

// File: rtl/nvm_guard_timer.sv
module nvm_guard_timer #(
   parameter int CYCLE_CLKS = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic ending
);
   localparam int CW = $clog2(CYCLE_CLKS + 1);

   logic [CW-1:0] remain;

   if (CYCLE_CLKS < 1) begin : g_bad_len
      initial $fatal(1, "nvm_guard_timer: CYCLE_CLKS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (start) begin
         remain <= CW'(CYCLE_CLKS);
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign busy   = (remain != '0);
   assign ending = (remain == CW'(1));

   // a new cycle may only be launched from idle
   assert_no_restart_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

   // a running cycle stays busy until its last clock
   assert_runs_out_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ending) |=> busy);

endmodule

// File: rtl/nvm_guard_latch.sv
module nvm_guard_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic wel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (clr_req) begin
         wel <= 1'b0;
      end else if (set_req) begin
         wel <= 1'b1;
      end
   end

   assert_set_wins_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && !clr_req) |=> wel);

endmodule

// File: rtl/nvm_guard_status.sv
module nvm_guard_status
   import nvm_guard_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int PAGE_W     = 4,
   parameter int CYCLE_CLKS = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [7:0]        cmd_data,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [PAGE_W:0]   cmd_count,
   input  logic              wp_n,
   output logic [7:0]        status,
   output logic              wel,
   output logic              wip,
   output logic [1:0]        bp,
   output logic              cmd_acc,
   output logic              cmd_rej
);
   localparam int CNT_W = PAGE_W + 1;

   if (PAGE_W < 1 || PAGE_W >= ADDR_W - 2) begin : g_bad_page_w
      initial $fatal(1, "nvm_guard_status: PAGE_W must lie inside one quarter");
   end

   guard_op_e op;
   logic      busy, ending, prot_hit;
   logic      idle_cmd, stwr_ok, arwr_ok, start;
   logic      set_req, clr_req, accept;
   logic [ST_BP_W-1:0] bp_q;

   assign op       = guard_op_e'(cmd_op);
   assign idle_cmd = cmd_valid && !busy;

   nvm_guard_region #(.ADDR_W(ADDR_W)) u_region (
      .bp_code (bp_q),
      .addr    (cmd_addr),
      .hit     (prot_hit)
   );

   nvm_guard_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .busy   (busy),
      .ending (ending)
   );

   assign stwr_ok = idle_cmd && (op == GOP_STWR) && wel && wp_n;
   assign arwr_ok = idle_cmd && (op == GOP_ARWR) && wel && wp_n
                    && (cmd_count != CNT_W'(0)) && !prot_hit;
   assign start   = stwr_ok || arwr_ok;

   assign set_req = idle_cmd && (op == GOP_SETWE) && wp_n;
   assign clr_req = (idle_cmd && (op == GOP_CLRWE)) || ending || (!busy && !wp_n);

   nvm_guard_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .clr_req (clr_req),
      .wel     (wel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q <= '0;
      end else if (stwr_ok) begin
         bp_q <= cmd_data[ST_BP_LSB +: ST_BP_W];
      end
   end

   always_comb begin
      accept = 1'b0;
      if (cmd_valid) begin
         if (busy) begin
            accept = (op == GOP_STRD);
         end else begin
            unique case (op)
               GOP_SETWE, GOP_CLRWE, GOP_ARRD, GOP_STRD: accept = 1'b1;
               GOP_STWR, GOP_ARWR:                       accept = start;
               default:                                  accept = 1'b0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_acc <= 1'b0;
         cmd_rej <= 1'b0;
      end else begin
         cmd_acc <= accept;
         cmd_rej <= cmd_valid && !accept;
      end
   end

   always_comb begin
      status                              = '0;
      status[ST_BUSY_BIT]                 = busy;
      status[ST_WEL_BIT]                  = wel;
      status[ST_BP_LSB +: ST_BP_W]        = bp_q;
   end

   assign wip = busy;
   assign bp  = bp_q;

   assert_one_reply_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (cmd_acc ^ cmd_rej));

   assert_quiet_reply_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> (!cmd_acc && !cmd_rej));

   assert_protected_refused_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == GOP_ARWR && prot_hit) |=> cmd_rej);

   assert_pin_clears_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n && !busy) |=> !wel);

   assert_end_clears_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);

   assert_busy_read_refused_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && op == GOP_ARRD) |=> cmd_rej);

   assert_bp_source_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bp) |-> $past(cmd_valid && op == GOP_STWR && !busy && wel && wp_n));

   assert_zero_count_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == GOP_ARWR && cmd_count == CNT_W'(0)) |=> cmd_rej);

endmodule

// File: tb/nvm_guard_status_test.sv
module nvm_guard_status_test;
   localparam int CLK_PERIOD = 10;
   localparam int CYC        = 12;
   localparam int ADDR_W     = 9;
   localparam int PAGE_W     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [2:0]        cmd_op = '0;
   logic [7:0]        cmd_data = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [PAGE_W:0]   cmd_count = '0;
   logic              wp_n = 1'b1;
   logic [7:0]        status;
   logic              wel, wip, cmd_acc, cmd_rej;
   logic [1:0]        bp;

   nvm_guard_status #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_CLKS(CYC)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
      .wp_n(wp_n), .status(status), .wel(wel), .wip(wip), .bp(bp),
      .cmd_acc(cmd_acc), .cmd_rej(cmd_rej)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic       acc;
      logic       rej;
      logic [7:0] st;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    vectors = 0;
   int    fails = 0;
   bit    done = 1'b0;

   // reference state
   bit       m_wel = 0;
   int       m_left = 0;
   bit [1:0] m_bp = 0;
   bit       pin = 1;

   function automatic bit in_prot(input bit [1:0] code, input logic [ADDR_W-1:0] a);
      bit [1:0] q = a[ADDR_W-1 -: 2];
      case (code)
         2'd0: return 1'b0;
         2'd1: return q == 2'd3;
         2'd2: return q >= 2'd2;
         default: return 1'b1;
      endcase
   endfunction

   task automatic cyc(input bit v, input logic [2:0] op, input logic [7:0] d,
                      input logic [ADDR_W-1:0] a, input logic [PAGE_W:0] n,
                      input string tag);
      exp_t e;
      bit   busy, start;
      @(negedge clk);
      cmd_valid = v; cmd_op = op; cmd_data = d; cmd_addr = a; cmd_count = n;
      wp_n = pin;
      @(posedge clk);
      e.acc = 0; e.rej = 0; start = 0;
      busy = (m_left != 0);
      if (v) begin
         if (busy) begin
            if (op == 3'd6) e.acc = 1; else e.rej = 1;
         end else begin
            case (op)
               3'd1: begin e.acc = 1; m_wel = pin; end
               3'd2: begin e.acc = 1; m_wel = 0; end
               3'd3: if (m_wel && pin) begin e.acc = 1; m_bp = d[3:2]; start = 1; end
                     else e.rej = 1;
               3'd4: if (m_wel && pin && n != 0 && !in_prot(m_bp, a)) begin
                        e.acc = 1; start = 1;
                     end else e.rej = 1;
               3'd5, 3'd6: e.acc = 1;
               default: e.rej = 1;
            endcase
         end
      end
      if (busy) begin
         m_left--;
         if (m_left == 0) m_wel = 0;
      end else if (!pin) begin
         m_wel = 0;
      end
      if (start) m_left = CYC;
      e.st = {4'b0000, m_bp, m_wel, (m_left != 0)};
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] d,
                        input logic [ADDR_W-1:0] a, input logic [PAGE_W:0] n,
                        input string tag);
      cyc(1'b1, op, d, a, n, tag);
   endtask

   task automatic idle(input int k, input string tag);
      for (int i = 0; i < k; i++) cyc(1'b0, 3'd0, 8'h00, '0, '0, tag);
   endtask

   task automatic run_out(input string tag);
      while (m_left != 0) cyc(1'b0, 3'd0, 8'h00, '0, '0, tag);
   endtask

   // monitor: compares each clock's outputs with the queued expectation
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         vectors++;
         if ({cmd_acc, cmd_rej, status} !== {e.acc, e.rej, e.st} ||
             {bp, wel, wip} !== e.st[3:0]) begin
            fails++;
            $display("FAIL %s: actual acc=%b rej=%b st=%h bp=%b wel=%b wip=%b expected acc=%b rej=%b st=%h",
                     t, cmd_acc, cmd_rej, status, bp, wel, wip, e.acc, e.rej, e.st);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R11 watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      idle(2, "R1 reset state");

      issue(3'd4, 8'h00, 9'h010, 5'd1, "R5 write with latch clear");
      issue(3'd1, 8'h00, '0, '0, "R3 set latch");
      issue(3'd2, 8'h00, '0, '0, "R3 clear latch");
      issue(3'd1, 8'h00, '0, '0, "R3 set latch again");
      issue(3'd0, 8'h00, '0, '0, "R11 unknown code");

      pin = 0;
      idle(1, "R4 pin low clears latch");
      issue(3'd1, 8'h00, '0, '0, "R4 set under pin low");
      issue(3'd3, 8'h0C, '0, '0, "R5 status write under pin low");
      pin = 1;

      issue(3'd1, 8'h00, '0, '0, "R3 set latch");
      issue(3'd3, 8'hF4, '0, '0, "R9 status write code 01");
      issue(3'd5, 8'h00, '0, '0, "R8 read while busy");
      issue(3'd6, 8'h00, '0, '0, "R8 status read while busy");
      issue(3'd2, 8'h00, '0, '0, "R8 clear latch while busy");
      issue(3'd3, 8'h00, '0, '0, "R8 status write while busy");
      run_out("R6 cycle length");
      idle(1, "R6 after cycle");

      issue(3'd1, 8'h00, '0, '0, "R3 set under code 01");
      issue(3'd4, 8'h00, 9'h180, 5'd1, "R2 code 01 protected start");
      issue(3'd4, 8'h00, 9'h17F, 5'd16, "R2 code 01 open start");
      pin = 0;
      idle(4, "R7 pin low during cycle");
      pin = 1;
      run_out("R7 cycle not aborted");

      issue(3'd1, 8'h00, '0, '0, "R3 set latch");
      issue(3'd4, 8'h00, 9'h000, 5'd0, "R10 zero count");
      issue(3'd2, 8'h00, '0, '0, "R9 clear keeps code");
      pin = 0;
      idle(2, "R9 pin keeps code");
      pin = 1;

      issue(3'd1, 8'h00, '0, '0, "R3 set latch");
      issue(3'd3, 8'h08, '0, '0, "R9 status write code 10");
      run_out("R6 cycle length");
      issue(3'd1, 8'h00, '0, '0, "R3 set under code 10");
      issue(3'd4, 8'h00, 9'h100, 5'd2, "R2 code 10 protected start");
      issue(3'd4, 8'h00, 9'h0FF, 5'd1, "R2 code 10 open start");
      run_out("R6 cycle length");

      issue(3'd1, 8'h00, '0, '0, "R3 set latch");
      issue(3'd3, 8'h0C, '0, '0, "R9 status write code 11");
      run_out("R6 cycle length");
      issue(3'd1, 8'h00, '0, '0, "R3 set under code 11");
      issue(3'd4, 8'h00, 9'h000, 5'd1, "R2 code 11 protects all");
      issue(3'd3, 8'h00, '0, '0, "R9 status write code 00");
      run_out("R6 cycle length");
      issue(3'd1, 8'h00, '0, '0, "R3 set under code 00");
      issue(3'd4, 8'h00, 9'h1FF, 5'd1, "R2 code 00 top address");
      run_out("R6 cycle length");
      issue(3'd6, 8'h00, '0, '0, "R11 status read idle");
      idle(1, "R11 quiet");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule